// File: doc/BRIEF.md
# Sectored Read Prefetch Controller

This block schedules read prefetching for a bus bridge. The prefetch buffer is a ring of equal sectors, by default four sectors of 128 bytes each, which gives 512 bytes. An initiator's read arrives as one request: a start address, a byte count and a mode flag that selects conventional or split-transaction handling. The controller trims the count to the programmed limits. It then issues fetch commands on the target side, one sector at a time and in address order. It keeps a two-bit state for each sector, so the buffer refills as the initiator empties sectors.

The target side answers each fetch with a single fill pulse, and the fills arrive in the order the fetches were issued. The initiator side sees a sector become available for draining. It opens the sector with a start pulse and releases it with an end pulse. A master disconnect behaves differently in the two modes. In conventional mode it ends the transfer and throws away the buffered data. In split-transaction mode it is ignored, and the block keeps fetching until the whole trimmed count has arrived.

Top module: `sect_prefetch_ctrl`

## Requirements
- R1: After reset, `done` is 1, `fetch_valid` is 0 and `sect_state` is 0. `sect_state` holds two bits per sector, with sector i at bits [2i+1:2i]. The codes are FREE=0, PENDING=1, FULL=2 and DRAINING=3.
- R2: The effective byte count of a request is the smallest of `req_bytes` and `max_rd_bytes`. When `req_split` is 1, `split_limit` is also included in the minimum.
- R3: Fetch k of a request uses the address `req_addr + 128*k` and a length of 128, except for the last fetch, which carries the remainder (1 to 128). The lengths add up to the effective count, and no other fetch is issued.
- R4: Up to four fetches are issued back to back, with no drain needed, until every sector is PENDING. After that, one new fetch is issued for each sector that a drain frees.
- R5: `fetch_sector` and `drain_sector` both start at sector 0 on each accepted request. Each one steps through the sectors in round-robin order, and fills go to the sectors in the same order.
- R6: A fetch is issued only for a FREE sector, and the sector then becomes PENDING. A fill turns the oldest PENDING sector FULL. `drain_start` turns the sector at `drain_sector` from FULL to DRAINING, and it has no effect unless `drain_avail` is 1. `drain_end` returns a DRAINING sector to FREE.
- R7: In split-transaction mode, `mst_disc` has no effect. All remaining fetches are still issued, and `done` rises only after every sector has been filled and drained.
- R8: In conventional mode, `mst_disc` stops all further fetches. It returns FULL and DRAINING sectors to FREE in the next cycle. PENDING sectors go straight to FREE when their fill arrives and never become drainable.
- R9: `done` is 1 exactly when the remaining byte count is zero and every sector is FREE. A request is accepted only while `done` is 1; `req_valid` at any other time is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request strobe |
| req_addr | input | 32 | Request start address |
| req_bytes | input | 13 | Requested byte count |
| req_split | input | 1 | 1 selects split-transaction mode |
| max_rd_bytes | input | 13 | Programmed maximum read byte count |
| split_limit | input | 13 | Programmed split commitment limit |
| mst_disc | input | 1 | Originating master disconnected |
| fetch_valid | output | 1 | A fetch command is offered |
| fetch_ready | input | 1 | The target side accepts the fetch |
| fetch_addr | output | 32 | Fetch address |
| fetch_len | output | 8 | Fetch length in bytes |
| fetch_sector | output | 2 | Sector the fetch will fill |
| fill_valid | input | 1 | One fetch has completed |
| drain_avail | output | 1 | The sector at `drain_sector` is FULL |
| drain_sector | output | 2 | Next sector to drain |
| drain_start | input | 1 | The initiator begins draining the sector |
| drain_end | input | 1 | The initiator has finished the sector |
| sect_state | output | 8 | State of each sector, two bits per sector |
| done | output | 1 | No bytes remain and all sectors are FREE |

## Verification
The hardest state to reach is a conventional disconnect that lands while the ring holds a mix of FULL and still-PENDING sectors. The fills that arrive after it must be discarded, not turned into drainable data. The stimulus gets there by letting four fetches go out, returning only two fills, and then pulsing the disconnect. After that it delivers the late fills and checks that `done` rises without any drain. The split case is reached in a similar way. The disconnect is pulsed while the ring is full, and then alternating fill and drain steps must still bring out the fifth fetch. A scoreboard built from the trimmed count catches any address, length or sector that is out of order.

// File: rtl/spf_pkg.sv
package spf_pkg;
   typedef enum logic [1:0] {
      SECT_FREE     = 2'd0,
      SECT_PENDING  = 2'd1,
      SECT_FULL     = 2'd2,
      SECT_DRAINING = 2'd3
   } sect_st_e;
endpackage

// File: rtl/spf_limit.sv
module spf_limit #(
   parameter int CNT_W    = 13,
   parameter bit SPLIT_EN = 1'b1
) (
   input  logic [CNT_W-1:0] req_bytes,
   input  logic [CNT_W-1:0] max_rd,
   input  logic [CNT_W-1:0] split_lim,
   input  logic             split,
   output logic [CNT_W-1:0] eff_o
);
   logic [CNT_W-1:0] cap_rd;

   assign cap_rd = (max_rd < req_bytes) ? max_rd : req_bytes;

   generate
      if (SPLIT_EN) begin : g_split
         assign eff_o = (split && (split_lim < cap_rd)) ? split_lim : cap_rd;
      end else begin : g_plain
         logic unused_split;
         assign unused_split = split ^ (^split_lim);
         assign eff_o = cap_rd;
      end
   endgenerate
endmodule

// File: rtl/spf_sector_bank.sv
module spf_sector_bank
   import spf_pkg::*;
#(
   parameter int NUM_SECT = 4,
   localparam int PW      = $clog2(NUM_SECT)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clear,
   input  logic                  flush,
   input  logic                  discard,
   input  logic                  fire,
   input  logic                  fill,
   input  logic                  dstart,
   input  logic                  dend,
   input  logic [PW-1:0]         iss_ptr,
   input  logic [PW-1:0]         fil_ptr,
   input  logic [PW-1:0]         drn_ptr,
   output logic [2*NUM_SECT-1:0] st_o
);
   logic [NUM_SECT-1:0] draining_v;

   generate
      for (genvar i = 0; i < NUM_SECT; i++) begin : g_sect
         sect_st_e st_q;

         always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
               st_q <= SECT_FREE;
            end else begin
               case (st_q)
                  SECT_FREE:
                     if (fire && (iss_ptr == PW'(i))) st_q <= SECT_PENDING;
                  SECT_PENDING:
                     if (fill && (fil_ptr == PW'(i)))
                        st_q <= discard ? SECT_FREE : SECT_FULL;
                  SECT_FULL:
                     if (flush) st_q <= SECT_FREE;
                     else if (dstart && (drn_ptr == PW'(i))) st_q <= SECT_DRAINING;
                  default:
                     if (flush || (dend && (drn_ptr == PW'(i)))) st_q <= SECT_FREE;
               endcase
            end
         end

         assign st_o[2*i +: 2] = st_q;
         assign draining_v[i]  = (st_q == SECT_DRAINING);

         AST_ISSUE_ON_FREE: assert property (@(posedge clk) disable iff (!rst_n)
            (fire && iss_ptr == PW'(i)) |-> (st_q == SECT_FREE)); // R6
      end
   endgenerate

   AST_ONE_DRAINING: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(draining_v)); // R5
endmodule

// File: rtl/sect_prefetch_ctrl.sv
module sect_prefetch_ctrl
   import spf_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int CNT_W      = 13,
   parameter int SECT_BYTES = 128,
   parameter int NUM_SECT   = 4,
   parameter bit SPLIT_EN   = 1'b1,
   localparam int PW        = $clog2(NUM_SECT),
   localparam int LW        = $clog2(SECT_BYTES) + 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   input  logic [ADDR_W-1:0]     req_addr,
   input  logic [CNT_W-1:0]      req_bytes,
   input  logic                  req_split,
   input  logic [CNT_W-1:0]      max_rd_bytes,
   input  logic [CNT_W-1:0]      split_limit,
   input  logic                  mst_disc,
   output logic                  fetch_valid,
   input  logic                  fetch_ready,
   output logic [ADDR_W-1:0]     fetch_addr,
   output logic [LW-1:0]         fetch_len,
   output logic [PW-1:0]         fetch_sector,
   input  logic                  fill_valid,
   output logic                  drain_avail,
   output logic [PW-1:0]         drain_sector,
   input  logic                  drain_start,
   input  logic                  drain_end,
   output logic [2*NUM_SECT-1:0] sect_state,
   output logic                  done
);
   generate
      if (NUM_SECT < 2 || (NUM_SECT & (NUM_SECT - 1)) != 0) begin : g_bad_sect
         $error("NUM_SECT must be a power of two, at least 2");
      end
      if (CNT_W <= LW) begin : g_bad_cnt
         $error("CNT_W must exceed the sector length width");
      end
   endgenerate

   localparam logic [CNT_W-1:0] SECT_C = CNT_W'(SECT_BYTES);

   function automatic sect_st_e st_at(input logic [2*NUM_SECT-1:0] v,
                                      input logic [PW-1:0] p);
      return sect_st_e'(v[2*int'(p) +: 2]);
   endfunction

   logic [CNT_W-1:0]  rem_q, eff;
   logic [ADDR_W-1:0] addr_q;
   logic              stop_q, split_q;
   logic [PW-1:0]     iss_ptr, fil_ptr, drn_ptr;
   logic              accept, disc_conv, fire, fill_ok, dstart_ok, dend_ok;

   spf_limit #(.CNT_W(CNT_W), .SPLIT_EN(SPLIT_EN)) u_limit (
      .req_bytes (req_bytes),
      .max_rd    (max_rd_bytes),
      .split_lim (split_limit),
      .split     (req_split),
      .eff_o     (eff)
   );

   assign done        = (rem_q == '0) && (sect_state == '0);
   assign accept      = req_valid && done;
   assign disc_conv   = mst_disc && !split_q && !done;
   assign fetch_valid = (rem_q != '0) && (st_at(sect_state, iss_ptr) == SECT_FREE);
   assign fire        = fetch_valid && fetch_ready && !disc_conv;
   assign fill_ok     = fill_valid && (st_at(sect_state, fil_ptr) == SECT_PENDING);
   assign drain_avail = (st_at(sect_state, drn_ptr) == SECT_FULL);
   assign dstart_ok   = drain_start && drain_avail;
   assign dend_ok     = drain_end && (st_at(sect_state, drn_ptr) == SECT_DRAINING);

   assign fetch_len    = (rem_q >= SECT_C) ? LW'(SECT_BYTES) : rem_q[LW-1:0];
   assign fetch_addr   = addr_q;
   assign fetch_sector = iss_ptr;
   assign drain_sector = drn_ptr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem_q   <= '0;
         addr_q  <= '0;
         stop_q  <= 1'b0;
         split_q <= 1'b0;
         iss_ptr <= '0;
         fil_ptr <= '0;
         drn_ptr <= '0;
      end else if (accept) begin
         rem_q   <= eff;
         addr_q  <= req_addr;
         split_q <= req_split;
         stop_q  <= 1'b0;
         iss_ptr <= '0;
         fil_ptr <= '0;
         drn_ptr <= '0;
      end else begin
         if (disc_conv) begin
            rem_q  <= '0;
            stop_q <= 1'b1;
         end else if (fire) begin
            rem_q <= rem_q - CNT_W'(fetch_len);
         end
         if (fire) begin
            addr_q  <= addr_q + ADDR_W'(SECT_BYTES);
            iss_ptr <= iss_ptr + 1'b1;
         end
         if (fill_ok) fil_ptr <= fil_ptr + 1'b1;
         if (dend_ok) drn_ptr <= drn_ptr + 1'b1;
      end
   end

   spf_sector_bank #(.NUM_SECT(NUM_SECT)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (accept),
      .flush   (disc_conv),
      .discard (stop_q || disc_conv),
      .fire    (fire),
      .fill    (fill_ok),
      .dstart  (dstart_ok),
      .dend    (dend_ok),
      .iss_ptr (iss_ptr),
      .fil_ptr (fil_ptr),
      .drn_ptr (drn_ptr),
      .st_o    (sect_state)
   );

   AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_valid |-> (fetch_len != '0 && fetch_len <= LW'(SECT_BYTES))); // R3
   AST_FIRE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> (st_at(sect_state, $past(iss_ptr)) == SECT_PENDING)); // R6
   AST_CONV_DISC_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      disc_conv |=> (!fetch_valid && !drain_avail)); // R8
   AST_SPLIT_DISC_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (mst_disc && split_q && !done)
         |=> (rem_q == $past(rem_q) - ($past(fire) ? CNT_W'($past(fetch_len)) : '0))); // R7
   AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && eff != '0) |=> !done); // R9
endmodule

// File: tb/sim_sect_prefetch_ctrl.sv
`timescale 1ns/1ps
module sim_sect_prefetch_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_split = 1'b0, mst_disc = 1'b0;
   logic [31:0] req_addr = '0;
   logic [12:0] req_bytes = '0, max_rd_bytes = 13'd4096, split_limit = 13'd4096;
   logic        fetch_ready = 1'b1, fill_valid = 1'b0;
   logic        drain_start = 1'b0, drain_end = 1'b0;
   logic        fetch_valid, drain_avail, done;
   logic [31:0] fetch_addr;
   logic [7:0]  fetch_len;
   logic [1:0]  fetch_sector, drain_sector;
   logic [7:0]  sect_state;

   int checks = 0, errors = 0, fires = 0, f0;
   bit finished = 0;
   logic [31:0] q_addr[$];
   logic [7:0]  q_len[$];
   logic [1:0]  q_sec[$];

   always #2 clk = ~clk;

   sect_prefetch_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_bytes(req_bytes), .req_split(req_split), .max_rd_bytes(max_rd_bytes),
      .split_limit(split_limit), .mst_disc(mst_disc), .fetch_valid(fetch_valid),
      .fetch_ready(fetch_ready), .fetch_addr(fetch_addr), .fetch_len(fetch_len),
      .fetch_sector(fetch_sector), .fill_valid(fill_valid), .drain_avail(drain_avail),
      .drain_sector(drain_sector), .drain_start(drain_start), .drain_end(drain_end),
      .sect_state(sect_state), .done(done)
   );

   task automatic chk(input bit ok, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   task automatic tick(); @(posedge clk); #1; endtask
   task automatic idle(input int n);
      for (int i = 0; i < n; i++) tick();
      @(negedge clk);
   endtask

   always @(negedge clk) begin
      if (rst_n && fetch_valid && fetch_ready) begin
         fires++;
         if (q_addr.size() == 0) begin
            chk(1'b0, "R3 unexpected fetch", fetch_addr, 32'h0);
         end else begin
            logic [31:0] ea; logic [7:0] el; logic [1:0] es;
            ea = q_addr.pop_front(); el = q_len.pop_front(); es = q_sec.pop_front();
            chk(fetch_addr == ea, "R3 fetch address", fetch_addr, ea);
            chk(fetch_len == el, "R3 fetch length", {24'h0, fetch_len}, {24'h0, el});
            chk(fetch_sector == es, "R5 fetch sector", {30'h0, fetch_sector}, {30'h0, es});
         end
      end
   end

   task automatic do_req(input logic [31:0] a, input int b, input bit sp,
                         input int mx, input int sl, input int nmax);
      int e, n;
      e = b;
      if (mx < e) e = mx;
      if (sp && sl < e) e = sl;
      n = 0;
      for (int off = 0; off < e && n < nmax; off += 128) begin
         q_addr.push_back(a + off);
         q_len.push_back(8'((e - off) > 128 ? 128 : (e - off)));
         q_sec.push_back(2'(n));
         n++;
      end
      tick();
      req_addr = a; req_bytes = 13'(b); req_split = sp;
      max_rd_bytes = 13'(mx); split_limit = 13'(sl); req_valid = 1'b1;
      tick();
      req_valid = 1'b0;
   endtask

   task automatic fill_one(); tick(); fill_valid = 1'b1; tick(); fill_valid = 1'b0; endtask

   task automatic drain_one();
      int w;
      w = 0;
      @(negedge clk);
      while (!drain_avail && w < 100) begin @(negedge clk); w++; end
      chk(drain_avail == 1'b1, "R6 drain never available", {31'h0, drain_avail}, 32'h1);
      tick(); drain_start = 1'b1;
      tick(); drain_start = 1'b0; drain_end = 1'b1;
      tick(); drain_end = 1'b0;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #800000;
      chk(1'b0, "watchdog expired", 32'h0, 32'h1);
      finish_run();
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      chk(done == 1'b1, "R1 done after reset", {31'h0, done}, 32'h1);
      chk(fetch_valid == 1'b0, "R1 no fetch after reset", {31'h0, fetch_valid}, 32'h0);
      chk(sect_state == 8'h00, "R1 sectors free", {24'h0, sect_state}, 32'h0);

      // drain_start with nothing FULL is ignored
      tick(); drain_start = 1'b1; tick(); drain_start = 1'b0;
      idle(1);
      chk(sect_state == 8'h00, "R6 stray drain_start", {24'h0, sect_state}, 32'h0);

      // conventional, 300 bytes
      f0 = fires;
      do_req(32'h1000, 300, 0, 4096, 4096, 99);
      idle(8);
      chk(fires - f0 == 3, "R3 fetch count 300B", fires - f0, 3);
      chk(sect_state == 8'h15, "R6 pending after fetch", {24'h0, sect_state}, 32'h15);
      chk(done == 1'b0, "R9 busy", {31'h0, done}, 32'h0);
      for (int k = 0; k < 3; k++) fill_one();
      idle(1);
      chk(sect_state == 8'h2A, "R6 full after fill", {24'h0, sect_state}, 32'h2A);
      chk(drain_sector == 2'd0, "R5 drain starts at 0", {30'h0, drain_sector}, 32'h0);
      for (int k = 0; k < 3; k++) drain_one();
      idle(1);
      chk(done == 1'b1, "R9 done after drain", {31'h0, done}, 32'h1);

      // cap by max read count
      f0 = fires;
      do_req(32'h2000, 1000, 0, 256, 4096, 99);
      idle(8);
      chk(fires - f0 == 2, "R2 max read cap", fires - f0, 2);
      for (int k = 0; k < 2; k++) begin fill_one(); drain_one(); end
      idle(2);
      chk(done == 1'b1, "R2 done after cap", {31'h0, done}, 32'h1);

      // split mode, max read is the smaller limit
      f0 = fires;
      do_req(32'h3000, 500, 1, 200, 640, 99);
      idle(8);
      chk(fires - f0 == 2, "R2 split min limit", fires - f0, 2);
      for (int k = 0; k < 2; k++) begin fill_one(); drain_one(); end
      idle(2);
      chk(done == 1'b1, "R2 done split min", {31'h0, done}, 32'h1);

      // large conventional read with refills
      f0 = fires;
      do_req(32'h10000, 1024, 0, 4096, 4096, 99);
      idle(8);
      chk(fires - f0 == 4, "R4 buffer fill first", fires - f0, 4);
      chk(sect_state == 8'h55, "R4 all pending", {24'h0, sect_state}, 32'h55);
      chk(fetch_valid == 1'b0, "R4 no fetch when full", {31'h0, fetch_valid}, 32'h0);
      tick(); req_addr = 32'h90000; req_bytes = 13'd128; req_valid = 1'b1;
      tick(); req_valid = 1'b0;
      idle(4);
      chk(fires - f0 == 4, "R9 busy request ignored", fires - f0, 4);
      fill_one(); drain_one();
      idle(4);
      chk(fires - f0 == 5, "R4 refill after drain", fires - f0, 5);
      for (int k = 0; k < 7; k++) begin fill_one(); drain_one(); end
      idle(4);
      chk(fires - f0 == 8, "R4 total fetches", fires - f0, 8);
      chk(done == 1'b1, "R9 done after large", {31'h0, done}, 32'h1);

      // split mode with disconnect
      f0 = fires;
      do_req(32'h20000, 1024, 1, 4096, 640, 99);
      idle(8);
      chk(fires - f0 == 4, "R7 initial fetches", fires - f0, 4);
      tick(); mst_disc = 1'b1; tick(); mst_disc = 1'b0;
      idle(2);
      chk(sect_state == 8'h55, "R7 disconnect ignored", {24'h0, sect_state}, 32'h55);
      chk(done == 1'b0, "R7 still busy", {31'h0, done}, 32'h0);
      fill_one(); drain_one();
      idle(4);
      chk(fires - f0 == 5, "R7 fetch after disconnect", fires - f0, 5);
      for (int k = 0; k < 4; k++) begin fill_one(); drain_one(); end
      idle(2);
      chk(done == 1'b1, "R7 done after all data", {31'h0, done}, 32'h1);

      // conventional with disconnect
      f0 = fires;
      do_req(32'h30000, 1024, 0, 4096, 4096, 4);
      idle(8);
      chk(fires - f0 == 4, "R8 initial fetches", fires - f0, 4);
      fill_one(); fill_one();
      idle(1);
      chk(sect_state == 8'h5A, "R6 mixed full and pending", {24'h0, sect_state}, 32'h5A);
      tick(); mst_disc = 1'b1; tick(); mst_disc = 1'b0;
      @(negedge clk);
      chk(sect_state == 8'h50, "R8 full sectors flushed", {24'h0, sect_state}, 32'h50);
      chk(drain_avail == 1'b0, "R8 nothing drainable", {31'h0, drain_avail}, 32'h0);
      chk(done == 1'b0, "R8 pending outstanding", {31'h0, done}, 32'h0);
      idle(4);
      chk(fires - f0 == 4, "R8 no more fetches", fires - f0, 4);
      fill_one(); fill_one();
      idle(1);
      chk(sect_state == 8'h00, "R8 late fills discarded", {24'h0, sect_state}, 32'h0);
      chk(drain_avail == 1'b0, "R8 late fill not drainable", {31'h0, drain_avail}, 32'h0);
      chk(done == 1'b1, "R9 done after discard", {31'h0, done}, 32'h1);

      // new request restarts at sector 0
      f0 = fires;
      do_req(32'h40000, 128, 0, 4096, 4096, 99);
      idle(6);
      chk(fires - f0 == 1, "R5 restart fetch", fires - f0, 1);
      fill_one();
      idle(1);
      chk(drain_sector == 2'd0, "R5 drain restarts at 0", {30'h0, drain_sector}, 32'h0);
      drain_one();
      idle(2);
      chk(done == 1'b1, "R9 final done", {31'h0, done}, 32'h1);
      chk(q_addr.size() == 0, "R3 all expected fetches seen", q_addr.size(), 0);
      finish_run();
   end
endmodule